// File: doc/BRIEF.md
# Bus Target Address Claim

This block sits on the target side of a shared parallel bus. It listens for the start of each transaction. A transaction starts on the clock edge where the active-low frame line is sampled low after it was sampled high. On that edge the block latches the address lines and the command lines. In the cycles that follow, it checks the latched values against a programmable window. If they match, it drives its active-low device-select output low after a programmed delay of one, two or three edges. It can also act as the catch-all target, claiming accesses that no other agent has taken. For such a claim, the address must fall inside a low 16-bit I/O range or a low 24-bit memory range, and the claim comes on a later, fixed edge.

The block is built around a four-state machine:
- **IDLE**: waits for the frame start. The *start* transition goes to DECODE.
- **DECODE**: counts edges since the capture. Its transitions are:
  - *positive claim*: the window matches and the programmed delay has elapsed. Goes to CLAIM.
  - *subtractive claim*: goes to CLAIM on the subtractive edge.
  - *give up*: nothing can claim any longer. Goes to IGNORE.
  - *abandon*: the frame line is released. Goes to IDLE.
- **CLAIM**: holds device-select low. The *release* transition goes to IDLE when the frame line is sampled high.
- **IGNORE**: waits out a transaction that is not ours. The *end* transition goes to IDLE when the frame line is sampled high.

While it claims a transaction, local logic receives a hit flag, the kind of claim (window or subtractive), the space, the direction and the latched address.

Top module: `bac_top`

## Requirements
- R1: After reset, devsel_n is 1 and claim_active, claim_sub, claim_io, claim_write and claim_addr are all 0.
- R2: Address and command are latched only on the start edge. Later values on ad and cbe_n do not change the decision, and claim_addr reports the latched address.
- R3: Command values on cbe_n are decoded as follows, and every other value is never claimed:
  - 4'b0010: I/O read.
  - 4'b0011: I/O write.
  - 4'b0110: memory read.
  - 4'b0111: memory write.
- R4: A window hit requires all three of the following:
  - cfg_pos_en is 1.
  - The command space matches cfg_win_io (1 = I/O, 0 = memory).
  - (addr XOR cfg_win_base) AND cfg_win_mask is zero.
- R5: On a window hit, devsel_n is low after start-edge+1 for cfg_speed 2'b00, +2 for 2'b01, and +3 for 2'b10 or 2'b11.
- R6: The subtractive claim works as follows:
  - It applies with cfg_sub_en=1 and no window hit, on a valid command whose address is in range. For I/O, addr[31:16] must be 0. For memory, addr[31:24] must be 0.
  - devsel_n goes low after start-edge+4, or after start-edge+3 when cfg_sub_early=1.
  - A window hit always takes its own timing instead.
- R7: If devsel_in_n is sampled low on any edge from start-edge+1 up to and including the subtractive edge, no subtractive claim is made.
- R8: Once low, devsel_n stays low while frame_n is sampled low. It returns to 1 on the edge after frame_n is sampled high.
- R9: If frame_n is sampled high before the claim edge, the transaction is dropped and no claim follows.
- R10: While devsel_n is low, the claim outputs are set as follows:
  - claim_active is 1.
  - claim_sub is 1 only for a subtractive claim.
  - claim_io and claim_write give the command space and direction.
  - claim_addr gives the latched address.
- R11: A new transaction starts only on a high-to-low transition of frame_n. A change of the bus during a transaction that is not ours never starts a claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low transaction frame from the initiator |
| ad | input | 32 | Multiplexed address/data lines |
| cbe_n | input | 4 | Command code during the address cycle |
| devsel_in_n | input | 1 | Device-select as driven by other agents, active low |
| cfg_pos_en | input | 1 | Enables window decoding |
| cfg_win_io | input | 1 | Window space: 1 = I/O, 0 = memory |
| cfg_win_base | input | 32 | Window base address |
| cfg_win_mask | input | 32 | Address bits compared against the base |
| cfg_speed | input | 2 | Window claim delay: 00 fast, 01 medium, 10/11 slow |
| cfg_sub_en | input | 1 | Enables the subtractive claim |
| cfg_sub_early | input | 1 | Subtractive claim one edge earlier |
| devsel_n | output | 1 | Device-select driven by this target, active low |
| claim_active | output | 1 | This target holds the transaction |
| claim_sub | output | 1 | The claim was subtractive |
| claim_io | output | 1 | Claimed command is an I/O access |
| claim_write | output | 1 | Claimed command is a write |
| claim_addr | output | 32 | Latched address of the claimed transaction |

## Verification
A wrong edge count in DECODE shows up as devsel_n falling one or more edges early or late relative to the start edge. The bench measures that edge position exactly for every delay setting. A state machine stuck in CLAIM or IGNORE shows up on the edge after frame_n rises: either devsel_n stays low, or the next transaction goes unclaimed. A stale latched address or command shows up in claim_addr on the first claimed edge, or as a claim that the bus no longer justifies, because the bench scrambles ad and cbe_n immediately after the start edge.

// File: rtl/bac_pkg.sv
package bac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CLAIM,
        ST_IGNORE
    } claim_state_e;

    typedef enum logic [1:0] {
        SPD_FAST   = 2'b00,
        SPD_MEDIUM = 2'b01,
        SPD_SLOW   = 2'b10,
        SPD_SLOW_X = 2'b11
    } speed_e;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/bac_capture.sv
module bac_capture #(
    parameter int AW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          frame_n,
    input  logic [AW-1:0] ad,
    input  logic [CW-1:0] cbe_n,
    output logic          take,
    output logic [AW-1:0] cap_addr,
    output logic [CW-1:0] cap_cmd
);

    logic frame_q;

    // start edge: frame seen high last edge, low now, and the sequencer is free
    assign take = arm & frame_q & ~frame_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q  <= 1'b1;
            cap_addr <= '0;
            cap_cmd  <= '0;
        end else begin
            frame_q <= frame_n;
            if (take) begin
                cap_addr <= ad;
                cap_cmd  <= cbe_n;
            end
        end
    end

endmodule

// File: rtl/bac_decode.sv
module bac_decode
    import bac_pkg::*;
#(
    parameter int AW           = 32,
    parameter int CW           = 4,
    parameter int IO_SUB_BITS  = 16,
    parameter int MEM_SUB_BITS = 24
) (
    input  logic [AW-1:0] cap_addr,
    input  logic [CW-1:0] cap_cmd,
    input  logic          cfg_pos_en,
    input  logic          cfg_win_io,
    input  logic [AW-1:0] cfg_win_base,
    input  logic [AW-1:0] cfg_win_mask,
    input  logic          cfg_sub_en,
    output logic          cmd_io,
    output logic          cmd_wr,
    output logic          pos_hit,
    output logic          sub_cand
);

    logic cmd_ok;
    logic io_low;
    logic mem_low;
    logic addr_match;

    always_comb begin
        cmd_ok = 1'b1;
        cmd_io = 1'b0;
        cmd_wr = 1'b0;
        unique case (cap_cmd)
            CMD_IO_RD:  cmd_io = 1'b1;
            CMD_IO_WR:  begin cmd_io = 1'b1; cmd_wr = 1'b1; end
            CMD_MEM_RD: cmd_io = 1'b0;
            CMD_MEM_WR: cmd_wr = 1'b1;
            default:    cmd_ok = 1'b0;
        endcase
    end

    generate
        if (IO_SUB_BITS < AW) begin : g_io_rng
            assign io_low = ~|cap_addr[AW-1:IO_SUB_BITS];
        end else begin : g_io_all
            assign io_low = 1'b1;
        end
        if (MEM_SUB_BITS < AW) begin : g_mem_rng
            assign mem_low = ~|cap_addr[AW-1:MEM_SUB_BITS];
        end else begin : g_mem_all
            assign mem_low = 1'b1;
        end
    endgenerate

    assign addr_match = ~|((cap_addr ^ cfg_win_base) & cfg_win_mask);
    assign pos_hit    = cfg_pos_en & cmd_ok & (cmd_io == cfg_win_io) & addr_match;
    assign sub_cand   = cfg_sub_en & cmd_ok & (cmd_io ? io_low : mem_low);

endmodule

// File: rtl/bac_claim_fsm.sv
module bac_claim_fsm
    import bac_pkg::*;
#(
    parameter int SUB_LATE  = 4,
    parameter int SUB_EARLY = 3,
    localparam int CNT_W    = $clog2(SUB_LATE + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       frame_n,
    input  logic       devsel_in_n,
    input  logic       pos_hit,
    input  logic       sub_cand,
    input  logic [1:0] cfg_speed,
    input  logic       cfg_sub_early,
    output logic       idle,
    output logic       devsel_n,
    output logic       claim_active,
    output logic       claim_sub
);

    claim_state_e     state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] pos_tgt;
    logic [CNT_W-1:0] sub_tgt;
    logic             other_seen;
    logic             sub_q;
    logic             load_sub;

    assign cnt_nx  = cnt + CNT_W'(1);
    assign sub_tgt = cfg_sub_early ? CNT_W'(SUB_EARLY) : CNT_W'(SUB_LATE);

    always_comb begin
        unique case (speed_e'(cfg_speed))
            SPD_FAST:   pos_tgt = CNT_W'(1);
            SPD_MEDIUM: pos_tgt = CNT_W'(2);
            SPD_SLOW:   pos_tgt = CNT_W'(3);
            SPD_SLOW_X: pos_tgt = CNT_W'(3);
            default:    pos_tgt = CNT_W'(3);
        endcase
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        load_sub = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (take) state_nx = ST_DECODE;
            end
            ST_DECODE: begin
                if (frame_n) begin
                    state_nx = ST_IDLE;
                end else if (pos_hit) begin
                    if (cnt_nx == pos_tgt) state_nx = ST_CLAIM;
                end else if (sub_cand && !other_seen && devsel_in_n) begin
                    if (cnt_nx == sub_tgt) begin
                        state_nx = ST_CLAIM;
                        load_sub = 1'b1;
                    end
                end else begin
                    state_nx = ST_IGNORE;
                end
            end
            ST_CLAIM: begin
                if (frame_n) state_nx = ST_IDLE;
            end
            ST_IGNORE: begin
                if (frame_n) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and decode bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            other_seen <= 1'b0;
            sub_q      <= 1'b0;
        end else begin
            state <= state_nx;
            if (take) begin
                cnt        <= '0;
                other_seen <= 1'b0;
            end else if (state == ST_DECODE) begin
                cnt <= cnt_nx;
                if (!devsel_in_n) other_seen <= 1'b1;
            end
            if (state == ST_DECODE && state_nx == ST_CLAIM) sub_q <= load_sub;
        end
    end

    // outputs
    always_comb begin
        idle         = (state == ST_IDLE);
        claim_active = (state == ST_CLAIM);
        devsel_n     = ~claim_active;
        claim_sub    = claim_active & sub_q;
    end

    AST_POS_WITHIN3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && !claim_sub) |-> ($past(cnt) < CNT_W'(3))); // R5

    AST_SUB_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && claim_sub) |-> ($past(cnt) >= CNT_W'(SUB_EARLY - 1))); // R6

    AST_SUB_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n) && claim_sub) |-> ($past(devsel_in_n) && !$past(other_seen))); // R7

    AST_HOLD_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && !frame_n) |=> !devsel_n); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n && frame_n) |=> devsel_n); // R8

endmodule

// File: rtl/bac_top.sv
module bac_top #(
    parameter int AW           = 32,
    parameter int CW           = 4,
    parameter int IO_SUB_BITS  = 16,
    parameter int MEM_SUB_BITS = 24,
    parameter int SUB_LATE     = 4,
    parameter int SUB_EARLY    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_n,
    input  logic [AW-1:0] ad,
    input  logic [CW-1:0] cbe_n,
    input  logic          devsel_in_n,
    input  logic          cfg_pos_en,
    input  logic          cfg_win_io,
    input  logic [AW-1:0] cfg_win_base,
    input  logic [AW-1:0] cfg_win_mask,
    input  logic [1:0]    cfg_speed,
    input  logic          cfg_sub_en,
    input  logic          cfg_sub_early,
    output logic          devsel_n,
    output logic          claim_active,
    output logic          claim_sub,
    output logic          claim_io,
    output logic          claim_write,
    output logic [AW-1:0] claim_addr
);

    logic          take;
    logic          idle;
    logic [AW-1:0] cap_addr;
    logic [CW-1:0] cap_cmd;
    logic          cmd_io;
    logic          cmd_wr;
    logic          pos_hit;
    logic          sub_cand;

    bac_capture #(.AW(AW), .CW(CW)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (idle),
        .frame_n  (frame_n),
        .ad       (ad),
        .cbe_n    (cbe_n),
        .take     (take),
        .cap_addr (cap_addr),
        .cap_cmd  (cap_cmd)
    );

    bac_decode #(
        .AW(AW), .CW(CW), .IO_SUB_BITS(IO_SUB_BITS), .MEM_SUB_BITS(MEM_SUB_BITS)
    ) u_dec (
        .cap_addr     (cap_addr),
        .cap_cmd      (cap_cmd),
        .cfg_pos_en   (cfg_pos_en),
        .cfg_win_io   (cfg_win_io),
        .cfg_win_base (cfg_win_base),
        .cfg_win_mask (cfg_win_mask),
        .cfg_sub_en   (cfg_sub_en),
        .cmd_io       (cmd_io),
        .cmd_wr       (cmd_wr),
        .pos_hit      (pos_hit),
        .sub_cand     (sub_cand)
    );

    bac_claim_fsm #(.SUB_LATE(SUB_LATE), .SUB_EARLY(SUB_EARLY)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .frame_n       (frame_n),
        .devsel_in_n   (devsel_in_n),
        .pos_hit       (pos_hit),
        .sub_cand      (sub_cand),
        .cfg_speed     (cfg_speed),
        .cfg_sub_early (cfg_sub_early),
        .idle          (idle),
        .devsel_n      (devsel_n),
        .claim_active  (claim_active),
        .claim_sub     (claim_sub)
    );

    assign claim_io    = claim_active & cmd_io;
    assign claim_write = claim_active & cmd_wr;
    assign claim_addr  = claim_active ? cap_addr : '0;

endmodule

// File: tb/sim_bac_top.sv
`timescale 1ns/1ps
module sim_bac_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        devsel_in_n = 1'b1;
    logic        cfg_pos_en = 1'b1;
    logic        cfg_win_io = 1'b0;
    logic [31:0] cfg_win_base = 32'h0000_1000;
    logic [31:0] cfg_win_mask = 32'hFFFF_FF00;
    logic [1:0]  cfg_speed = 2'b00;
    logic        cfg_sub_en = 1'b0;
    logic        cfg_sub_early = 1'b0;
    logic        devsel_n, claim_active, claim_sub, claim_io, claim_write;
    logic [31:0] claim_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int          first_j;
    logic        held, released, r_sub, r_io, r_wr;
    logic [31:0] r_addr;

    always #2.5 clk = ~clk;

    bac_top u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
        .devsel_in_n(devsel_in_n), .cfg_pos_en(cfg_pos_en), .cfg_win_io(cfg_win_io),
        .cfg_win_base(cfg_win_base), .cfg_win_mask(cfg_win_mask), .cfg_speed(cfg_speed),
        .cfg_sub_en(cfg_sub_en), .cfg_sub_early(cfg_sub_early), .devsel_n(devsel_n),
        .claim_active(claim_active), .claim_sub(claim_sub), .claim_io(claim_io),
        .claim_write(claim_write), .claim_addr(claim_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transaction; j counts edges after the start edge.
    task automatic run_txn(input logic [31:0] a, input logic [3:0] c, input int drop_at,
                           input int other_at, input int swap_at, input logic [31:0] swap_a);
        first_j = 0; r_sub = 0; r_io = 0; r_wr = 0; r_addr = '0;
        @(negedge clk);
        frame_n = 1'b0; ad = a; cbe_n = c;
        @(posedge clk);
        @(negedge clk);
        ad = 32'hDEAD_BEEF; cbe_n = 4'hF;
        if (!devsel_n) first_j = -1;
        for (int j = 1; j <= 6; j++) begin
            if (j == drop_at) frame_n = 1'b1;
            devsel_in_n = (j == other_at) ? 1'b0 : 1'b1;
            if (j == swap_at) begin ad = swap_a; cbe_n = c; end
            @(posedge clk);
            @(negedge clk);
            if (!devsel_n && first_j == 0) begin
                first_j = j; r_sub = claim_sub; r_io = claim_io;
                r_wr = claim_write; r_addr = claim_addr;
            end
        end
        held = !devsel_n;
        devsel_in_n = 1'b1;
        frame_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        released = devsel_n & !claim_active;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 devsel_n", devsel_n, 1);
        chk("R1 claim outputs", {claim_active, claim_sub, claim_io, claim_write}, 0);
        chk("R1 claim_addr", claim_addr, 0);
    endtask

    task automatic t_timing(input logic [1:0] spd, input int exp);
        cfg_speed = spd; cfg_win_io = 0;
        run_txn(32'h0000_1040, 4'b0110, 0, 0, 0, 0);
        chk("R5 claim edge", first_j, exp);
        chk("R8 held while frame low", held, 1);
        chk("R8 released after frame high", released, 1);
    endtask

    task automatic t_outputs();
        cfg_speed = 2'b00; cfg_win_io = 1; cfg_win_base = 32'h0000_0300;
        run_txn(32'h0000_0324, 4'b0011, 0, 0, 0, 0);
        chk("R10 io write claim edge", first_j, 1);
        chk("R10 claim_io", r_io, 1);
        chk("R10 claim_write", r_wr, 1);
        chk("R10 claim_sub", r_sub, 0);
        chk("R2 latched address", r_addr, 32'h0000_0324);
        cfg_win_io = 0; cfg_win_base = 32'h0000_1000;
        run_txn(32'h0000_10FC, 4'b0111, 0, 0, 0, 0);
        chk("R3 mem write claimed", first_j, 1);
        chk("R3 mem write flags", {r_io, r_wr}, 2'b01);
    endtask

    task automatic t_cmd_ignored();
        cfg_speed = 2'b00;
        run_txn(32'h0000_1040, 4'b1010, 0, 0, 0, 0);
        chk("R3 unknown command not claimed", first_j, 0);
        run_txn(32'h0000_1040, 4'b0100, 0, 0, 0, 0);
        chk("R3 code 0100 not claimed", first_j, 0);
    endtask

    task automatic t_window();
        run_txn(32'h0000_1140, 4'b0110, 0, 0, 0, 0);
        chk("R4 masked mismatch", first_j, 0);
        run_txn(32'h0000_1040, 4'b0010, 0, 0, 0, 0);
        chk("R4 space mismatch", first_j, 0);
        cfg_pos_en = 0;
        run_txn(32'h0000_1040, 4'b0110, 0, 0, 0, 0);
        chk("R4 window disabled", first_j, 0);
        cfg_pos_en = 1;
    endtask

    task automatic t_sub();
        cfg_sub_en = 1; cfg_sub_early = 0; cfg_speed = 2'b00;
        run_txn(32'h0000_8000, 4'b0010, 0, 0, 0, 0);
        chk("R6 io subtractive late edge", first_j, 4);
        chk("R6 claim_sub flag", r_sub, 1);
        run_txn(32'h0001_0000, 4'b0010, 0, 0, 0, 0);
        chk("R6 io out of 16-bit range", first_j, 0);
        run_txn(32'h00FF_0000, 4'b0110, 0, 0, 0, 0);
        chk("R6 mem in 24-bit range", first_j, 4);
        run_txn(32'h0100_0000, 4'b0110, 0, 0, 0, 0);
        chk("R6 mem out of 24-bit range", first_j, 0);
        cfg_sub_early = 1;
        run_txn(32'h0000_8000, 4'b0011, 0, 0, 0, 0);
        chk("R6 subtractive early edge", first_j, 3);
        run_txn(32'h0000_1040, 4'b0110, 0, 0, 0, 0);
        chk("R6 window takes precedence edge", first_j, 1);
        chk("R6 window claim not subtractive", r_sub, 0);
        cfg_sub_early = 0;
    endtask

    task automatic t_suppress();
        run_txn(32'h0000_8000, 4'b0010, 0, 2, 0, 0);
        chk("R7 other agent seen, no claim", first_j, 0);
        run_txn(32'h0000_8000, 4'b0010, 0, 4, 0, 0);
        chk("R7 other agent on claim edge", first_j, 0);
        run_txn(32'h0000_8000, 4'b0010, 0, 5, 0, 0);
        chk("R7 other agent after claim edge", first_j, 4);
        cfg_sub_en = 0;
    endtask

    task automatic t_abort();
        cfg_speed = 2'b10;
        run_txn(32'h0000_1040, 4'b0110, 2, 0, 0, 0);
        chk("R9 frame released before claim", first_j, 0);
        cfg_speed = 2'b00;
    endtask

    task automatic t_recapture();
        run_txn(32'h0000_5000, 4'b0110, 0, 0, 2, 32'h0000_1040);
        chk("R11 mid-transaction bus change", first_j, 0);
        chk("R2 decision from latched values", released, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_timing(2'b00, 1);
        t_timing(2'b01, 2);
        t_timing(2'b10, 3);
        t_timing(2'b11, 3);
        t_outputs();
        t_cmd_ignored();
        t_window();
        t_sub();
        t_suppress();
        t_abort();
        t_recapture();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule